// File: doc/BRIEF.md
# Bank Controller with Latched Real-Time Clock

This block decodes CPU writes into the upper address regions of a cartridge-style memory map. It holds a 7-bit ROM bank number, a RAM enable, and one select register. That select register points the external RAM window either at one of four RAM banks or at one of five clock registers. The ROM and RAM arrays are outside the block: it only drives the bank numbers and the window mode they need.

The embedded clock keeps seconds, minutes, hours and a 9-bit day count. It advances on a one-pulse-per-second tick input. A halt bit freezes it, and a sticky flag records a day-count wrap. The CPU never reads the running counters. A handshake (write 0, then write 1, to the latch region) copies them into a snapshot, and clock-register reads return that snapshot. CPU writes through the window load the running counters directly.

Top module: `banked_rtc_ctrl`

## Requirements
- R1: After reset: ROM bank is 1, RAM is disabled, RAM bank is 0, the window selects RAM, clock register index is 0, the latch flag is 0, and all running and snapshot clock fields are zero.
- R2: A write with addr[15:13]=0 enables RAM/clock access when the data is 0x0A and disables it when the data is 0x00. Any other data leaves the enable unchanged.
- R3: A write with addr[15:13]=1 sets the ROM bank to data[6:0], with 0 mapped to 1. Data bit 7 is ignored, and the bank changes on no other write.
- R4: A write with addr[15:13]=2 and data below 4 selects RAM bank data[1:0] and switches the window to RAM. Data 8 to 0x0C selects clock register (data-8) and switches the window to the clock. Any other value changes nothing.
- R5: A write with addr[15:13]=3 of 1 while unlatched copies the running clock, as it was before that edge, into the snapshot and sets the latch flag. A write of 0 while latched clears the flag. All other writes leave the flag and snapshot unchanged.
- R6: rtc_rdata_o shows the snapshot register picked by the index. Index 0 is seconds, 1 minutes, 2 hours and 3 day[7:0]. Index 4 is {overflow, halt, 5'b0, day[8]}.
- R7: On each tick, seconds step modulo 60, then minutes modulo 60 on a seconds wrap, then hours modulo 24 on a minutes wrap, and a wrap of the hours increments the day count.
- R8: The day counter is 9 bits. A tick that takes it from 511 to 0 sets the overflow flag, which only a CPU write to register 4 can clear.
- R9: While the halt bit is set, ticks do not change any clock field.
- R10: A write with addr[15:13]=5 while access is enabled and the window selects the clock loads the selected running field. Seconds and minutes take data[5:0], hours data[4:0], and day[7:0] data. Register 4 takes day[8]=bit 0, halt=bit 6 and overflow=bit 7. Such a write drops a tick that arrives in the same cycle. With access disabled or the window on RAM, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe |
| addr_i | input | 16 | CPU write address |
| wdata_i | input | 8 | CPU write data |
| tick_i | input | 1 | One-cycle pulse per second |
| rom_bank_o | output | 7 | Switchable ROM bank number |
| ram_en_o | output | 1 | RAM/clock window enabled |
| ram_bank_o | output | 2 | Selected RAM bank |
| rtc_sel_o | output | 1 | Window maps clock registers instead of RAM |
| rtc_idx_o | output | 3 | Selected clock register index |
| latched_o | output | 1 | Latch handshake flag |
| rtc_rdata_o | output | 8 | Snapshot value of the selected clock register |

## Verification
The bench drives random writes across all eight address regions with a fixed seed. Write data is biased toward small values so that the enable codes, bank zero and the select boundaries 3/4 and 0x0C/0x0D come up often. Ticks are mixed in at random. A bench model tracks every register, so a change from a write that should be ignored shows up as a mismatch. Directed sequences separate carry behaviour from plain stepping by presetting 59:59:23 with day 511 to reach the overflow wrap. They also freeze the clock with the halt bit, and collide a tick with a clock write. A latch written twice in a row shows that a second capture needs the 0-then-1 handshake.

// File: rtl/rtcbank_pkg.sv
package rtcbank_pkg;
  localparam int ROM_BANK_W = 7;
  localparam int RAM_BANK_W = 2;
  localparam int RAM_BANKS  = 1 << RAM_BANK_W;
  localparam int RTC_REGS   = 5;
  localparam int IDX_W      = $clog2(RTC_REGS);
  localparam int DAY_W      = 9;
  localparam int RTC_SEL_LO = 8;
  localparam int RTC_SEL_HI = RTC_SEL_LO + RTC_REGS - 1;

  typedef enum logic [2:0] {
    RGN_ENABLE = 3'd0,
    RGN_ROM    = 3'd1,
    RGN_SELECT = 3'd2,
    RGN_LATCH  = 3'd3,
    RGN_WINDOW = 3'd5
  } region_e;

  typedef struct packed {
    logic [5:0]       sec;
    logic [5:0]       min;
    logic [4:0]       hour;
    logic [DAY_W-1:0] day;
    logic             halt;
    logic             ovf;
  } rtc_time_t;

  function automatic logic [7:0] rtc_reg_view(rtc_time_t t, logic [IDX_W-1:0] idx);
    case (idx)
      0:       return {2'b00, t.sec};
      1:       return {2'b00, t.min};
      2:       return {3'b000, t.hour};
      3:       return t.day[7:0];
      4:       return {t.ovf, t.halt, 5'b00000, t.day[8]};
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import rtcbank_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [2:0]            region_i,
  input  logic [7:0]            wdata_i,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic                  ram_en_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  rtc_sel_o,
  output logic [IDX_W-1:0]      rtc_idx_o,
  output logic                  latched_o,
  output logic                  capture_o
);
  logic wr_en, wr_rom, wr_sel, wr_latch;
  logic [ROM_BANK_W-1:0] rom_val;

  assign wr_en    = wr_en_i && (region_i == RGN_ENABLE);
  assign wr_rom   = wr_en_i && (region_i == RGN_ROM);
  assign wr_sel   = wr_en_i && (region_i == RGN_SELECT);
  assign wr_latch = wr_en_i && (region_i == RGN_LATCH);
  assign rom_val  = wdata_i[ROM_BANK_W-1:0];
  assign capture_o = wr_latch && (wdata_i == 8'h01) && !latched_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_bank_o <= ROM_BANK_W'(1);
      ram_en_o   <= 1'b0;
      ram_bank_o <= '0;
      rtc_sel_o  <= 1'b0;
      rtc_idx_o  <= '0;
      latched_o  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wdata_i == 8'h0A)      ram_en_o <= 1'b1;
        else if (wdata_i == 8'h00) ram_en_o <= 1'b0;
      end
      if (wr_rom) rom_bank_o <= (rom_val == '0) ? ROM_BANK_W'(1) : rom_val;
      if (wr_sel) begin
        if (wdata_i < 8'(RAM_BANKS)) begin
          ram_bank_o <= wdata_i[RAM_BANK_W-1:0];
          rtc_sel_o  <= 1'b0;
        end else if (wdata_i >= 8'(RTC_SEL_LO) && wdata_i <= 8'(RTC_SEL_HI)) begin
          rtc_idx_o <= IDX_W'(wdata_i - 8'(RTC_SEL_LO));
          rtc_sel_o <= 1'b1;
        end
      end
      if (capture_o) latched_o <= 1'b1;
      else if (wr_latch && wdata_i == 8'h00 && latched_o) latched_o <= 1'b0;
    end
  end

  assert_rom_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_rom |=> $stable(rom_bank_o));
  assert_sel_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sel |=> $stable({rtc_sel_o, ram_bank_o, rtc_idx_o}));
  assert_latch_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_o |=> !$rose(latched_o));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtcbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cpu_wr_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic [7:0]       cpu_data_i,
  output rtc_time_t        live_o
);
  rtc_time_t stepped, loaded;
  logic c_sec, c_min, c_hour, c_day;

  always_comb begin
    stepped = live_o;
    c_sec   = live_o.sec  >= 6'd59;
    c_min   = c_sec && (live_o.min >= 6'd59);
    c_hour  = c_min && (live_o.hour >= 5'd23);
    c_day   = c_hour && (live_o.day == '1);
    stepped.sec = c_sec ? 6'd0 : live_o.sec + 6'd1;
    if (c_sec) stepped.min  = c_min ? 6'd0 : live_o.min + 6'd1;
    if (c_min) stepped.hour = c_hour ? 5'd0 : live_o.hour + 5'd1;
    if (c_hour) stepped.day = live_o.day + DAY_W'(1);
    if (c_day) stepped.ovf  = 1'b1;
  end

  always_comb begin
    loaded = live_o;
    case (cpu_idx_i)
      0: loaded.sec  = cpu_data_i[5:0];
      1: loaded.min  = cpu_data_i[5:0];
      2: loaded.hour = cpu_data_i[4:0];
      3: loaded.day[7:0] = cpu_data_i;
      4: begin
        loaded.day[8] = cpu_data_i[0];
        loaded.halt   = cpu_data_i[6];
        loaded.ovf    = cpu_data_i[7];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      live_o <= '0;
    else if (cpu_wr_i)                live_o <= loaded;
    else if (tick_i && !live_o.halt)  live_o <= stepped;
  end

  assert_halt_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_o.halt && !cpu_wr_i) |=> $stable(live_o));
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_o.ovf && !(cpu_wr_i && cpu_idx_i == IDX_W'(4))) |=> live_o.ovf);
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_wr_i && !tick_i) |=> $stable(live_o));
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtcbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  rtc_time_t        live_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       rdata_o
);
  rtc_time_t snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (capture_i) snap_q <= live_i;
  end

  assign rdata_o = rtc_reg_view(snap_q, idx_i);

  assert_snap_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(snap_q));
  assert_snap_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (snap_q == $past(live_i)));
endmodule

// File: rtl/banked_rtc_ctrl.sv
module banked_rtc_ctrl
  import rtcbank_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [15:0]           addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  tick_i,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic                  ram_en_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  rtc_sel_o,
  output logic [IDX_W-1:0]      rtc_idx_o,
  output logic                  latched_o,
  output logic [7:0]            rtc_rdata_o
);
  logic [2:0] region;
  logic       capture, cpu_rtc_wr;
  rtc_time_t  live;

  assign region     = addr_i[15:13];
  assign cpu_rtc_wr = wr_en_i && (region == RGN_WINDOW) && ram_en_o && rtc_sel_o;

  bank_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i,
    .region_i  (region),
    .wdata_i,
    .rom_bank_o, .ram_en_o, .ram_bank_o, .rtc_sel_o, .rtc_idx_o, .latched_o,
    .capture_o (capture)
  );

  rtc_counter u_clock (
    .clk_i, .rst_ni, .tick_i,
    .cpu_wr_i   (cpu_rtc_wr),
    .cpu_idx_i  (rtc_idx_o),
    .cpu_data_i (wdata_i),
    .live_o     (live)
  );

  rtc_snapshot u_snap (
    .clk_i, .rst_ni,
    .capture_i (capture),
    .live_i    (live),
    .idx_i     (rtc_idx_o),
    .rdata_o   (rtc_rdata_o)
  );

  assert_en_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && region == RGN_ENABLE) |=> $stable(ram_en_o));
endmodule

// File: tb/banked_rtc_ctrl_tb_top.sv
module banked_rtc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0, wr_en = 0, tick = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic [6:0]  rom_bank;
  logic        ram_en, rtc_sel, latched;
  logic [1:0]  ram_bank;
  logic [2:0]  rtc_idx;
  logic [7:0]  rtc_rdata;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_rtc_ctrl dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .tick_i(tick), .rom_bank_o(rom_bank), .ram_en_o(ram_en),
    .ram_bank_o(ram_bank), .rtc_sel_o(rtc_sel), .rtc_idx_o(rtc_idx),
    .latched_o(latched), .rtc_rdata_o(rtc_rdata)
  );

  // bench model: index 0..4 = sec,min,hour,day,{ovf,halt}
  int m_rom = 1, m_bank = 0, m_idx = 0;
  bit m_en = 0, m_sel = 0, m_lat = 0;
  int lv_sec = 0, lv_min = 0, lv_hr = 0, lv_day = 0; bit lv_halt = 0, lv_ovf = 0;
  int sn_sec = 0, sn_min = 0, sn_hr = 0, sn_day = 0; bit sn_halt = 0, sn_ovf = 0;

  function automatic int view(int idx, int s, int m, int h, int d, bit hl, bit ov);
    case (idx)
      0: return s; 1: return m; 2: return h; 3: return d & 255;
      4: return (int'(ov) << 7) | (int'(hl) << 6) | ((d >> 8) & 1);
      default: return 255;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_tick();
    if (lv_halt) return;
    if (lv_sec >= 59) begin
      lv_sec = 0;
      if (lv_min >= 59) begin
        lv_min = 0;
        if (lv_hr >= 23) begin
          lv_hr = 0;
          if (lv_day == 511) begin lv_day = 0; lv_ovf = 1; end
          else lv_day++;
        end else lv_hr++;
      end else lv_min++;
    end else lv_sec++;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d, output bit cw);
    cw = 0;
    case (a[15:13])
      3'd0: if (d == 8'h0A) m_en = 1; else if (d == 8'h00) m_en = 0;
      3'd1: m_rom = (d[6:0] == 0) ? 1 : int'(d[6:0]);
      3'd2: if (d < 4) begin m_bank = d; m_sel = 0; end
            else if (d >= 8 && d <= 12) begin m_idx = d - 8; m_sel = 1; end
      3'd3: if (d == 1 && !m_lat) begin
              m_lat = 1; sn_sec = lv_sec; sn_min = lv_min; sn_hr = lv_hr;
              sn_day = lv_day; sn_halt = lv_halt; sn_ovf = lv_ovf;
            end else if (d == 0 && m_lat) m_lat = 0;
      3'd5: if (m_en && m_sel) begin
              cw = 1;
              case (m_idx)
                0: lv_sec = d[5:0]; 1: lv_min = d[5:0]; 2: lv_hr = d[4:0];
                3: lv_day = (lv_day & 256) | d;
                default: begin lv_day = (lv_day & 255) | (int'(d[0]) << 8);
                  lv_halt = d[6]; lv_ovf = d[7]; end
              endcase
            end
      default: ;
    endcase
  endtask

  task automatic check_all();
    chk("R3 rom_bank", rom_bank, m_rom);
    chk("R2 ram_en", ram_en, m_en);
    chk("R4 ram_bank", ram_bank, m_bank);
    chk("R4 rtc_sel", rtc_sel, m_sel);
    chk("R4 rtc_idx", rtc_idx, m_idx);
    chk("R5 latched", latched, m_lat);
    chk("R6 rtc_rdata", rtc_rdata, view(m_idx, sn_sec, sn_min, sn_hr, sn_day, sn_halt, sn_ovf));
  endtask

  task automatic step(input logic we, input logic [15:0] a, input logic [7:0] d, input logic tk);
    bit cw;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; tick = tk;
    cw = 0;
    if (we) model_write(a, d, cw);
    if (tk && !cw) model_tick();
    @(negedge clk);
    wr_en = 0; tick = 0;
    check_all();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d); step(1, a, d, 0); endtask

  // latch the running clock and compare each field against the model's live values
  task automatic read_clock(input string tag);
    wr(16'h6000, 8'h00);
    wr(16'h6000, 8'h01);
    for (int i = 0; i < 5; i++) begin
      wr(16'h4000, 8'(8 + i));
      chk(tag, rtc_rdata, view(i, lv_sec, lv_min, lv_hr, lv_day, lv_halt, lv_ovf));
    end
  endtask

  task automatic set_clock(input int s, input int m, input int h, input int dl, input int r4);
    wr(16'h0000, 8'h0A);
    wr(16'h4000, 8'h08); wr(16'hA000, 8'(s));
    wr(16'h4000, 8'h09); wr(16'hA000, 8'(m));
    wr(16'h4000, 8'h0A); wr(16'hA000, 8'(h));
    wr(16'h4000, 8'h0B); wr(16'hA000, 8'(dl));
    wr(16'h4000, 8'h0C); wr(16'hA000, 8'(r4));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rom_bank", rom_bank, 1);
    chk("R1 ram_en", ram_en, 0);
    chk("R1 rtc_sel", rtc_sel, 0);
    chk("R1 latched", latched, 0);
    chk("R1 rdata", rtc_rdata, 0);
    rst_ni = 1;
    read_clock("R1 live clock zero");

    // R3 zero maps to one, bit 7 ignored
    wr(16'h2000, 8'h00); chk("R3 zero->1", rom_bank, 1);
    wr(16'h3FFF, 8'hC5); chk("R3 bit7 ignored", rom_bank, 8'h45);
    // R4 boundaries
    wr(16'h4000, 8'h03); wr(16'h4000, 8'h04); chk("R4 value 4 ignored", ram_bank, 3);
    wr(16'h4000, 8'h0D); chk("R4 value 0D ignored", rtc_sel, 0);
    // R10 write while window is on RAM or disabled is ignored
    wr(16'h0000, 8'h0A); wr(16'hA000, 8'h21);
    wr(16'h0000, 8'h00); wr(16'h4000, 8'h08); wr(16'hA000, 8'h22);
    read_clock("R10 ignored write");

    // R7/R8 carry chain and overflow
    set_clock(59, 59, 23, 8'hFF, 8'h01);
    step(0, 16'h0, 8'h0, 1);
    read_clock("R8 wrap sets overflow");
    chk("R8 ovf bit", rtc_rdata[7], 1);
    repeat (3) step(0, 16'h0, 8'h0, 1);
    read_clock("R8 overflow sticky");
    set_clock(58, 59, 22, 8'h10, 8'h00);
    repeat (3) step(0, 16'h0, 8'h0, 1);
    read_clock("R7 carry into hours");

    // R9 halt
    set_clock(10, 20, 5, 3, 8'h40);
    repeat (5) step(0, 16'h0, 8'h0, 1);
    read_clock("R9 halted");

    // R10 tick dropped on collision with a clock write
    set_clock(30, 1, 1, 1, 8'h00);
    wr(16'h4000, 8'h08);
    step(1, 16'hA000, 8'h05, 1);
    read_clock("R10 write beats tick");

    // R5 second capture needs the 0-then-1 handshake
    wr(16'h6000, 8'h00); wr(16'h6000, 8'h01);
    repeat (4) step(0, 16'h0, 8'h0, 1);
    wr(16'h6000, 8'h01);
    wr(16'h4000, 8'h08); chk("R5 relatch blocked", rtc_rdata, sn_sec);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = {3'($urandom_range(0, 7)), 13'($urandom)};
      d = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
      step($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 9) < 3);
    end
    read_clock("R7 random end state");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule